// File: doc/BRIEF.md
# Four-Level Translation Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a radix tree of translation tables held in memory. A request carries a 64-bit virtual address and an access kind, and it is sampled together with a root table address. The walker then fetches one 64-bit descriptor per level, up to four levels deep, over a simple request/response read port.

Every table is 4 KB and holds 512 eight-byte entries, so each level consumes a 9-bit slice of the address. The slices are taken from the most significant end downwards. The low 12 bits of the virtual address are the page offset and pass straight through to the result.

The result appears as a single-cycle response. A successful walk returns the physical address and the three permission bits of the leaf. A failed walk returns a fault with the level at which it stopped and a cause code. The walker handles one translation at a time and shows this through its ready output.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is 1 only while the walker is idle, and a request is taken when `req_valid` and `req_ready` are both 1. The walker holds `req_ready` at 0 from the cycle after acceptance until its response. Each accepted request produces exactly one `rsp_valid` pulse of one cycle, and `req_ready` returns to 1 in the following cycle.
- R2: If VA bits 63..48 are not all copies of bit 47, the response reports `rsp_fault`=1, `rsp_cause`=3 (non-canonical) and `rsp_level`=0, and no memory read is issued. Sign-extended addresses with bit 47 set are translated normally.
- R3: The descriptor read address at level L is {table base bits 47..12, index, 3'b000}. The index is VA[47:39] for L=0, VA[38:30] for L=1, VA[29:21] for L=2 and VA[20:12] for L=3. The level-0 table base is `root_base` with its low 12 bits cleared. `mem_req_addr` holds steady while `mem_req_valid` waits for `mem_req_ready`.
- R4: At levels 0 to 2, a descriptor whose bit 0 is 0, or whose bits 1..0 equal 01, ends the walk with `rsp_cause`=1 (invalid) and `rsp_level`=L.
- R5: At levels 0 to 2, a descriptor whose bits 1..0 equal 11 is a table descriptor. The next table base is its bits 47..12 followed by 12 zero bits, and all other descriptor bits are ignored.
- R6: At level 3, only bits 1..0 = 11 form a page descriptor. Any other pattern faults with `rsp_cause`=1 and `rsp_level`=3.
- R7: A successful walk gives `rsp_fault`=0, `rsp_cause`=0, `rsp_level`=3, `rsp_pa` = {leaf bits 47..12, VA[11:0]} and `rsp_perm` = leaf bits 4..2 (read, write, execute). Leaf bits 63..48 and 11..5 do not affect the result.
- R8: `req_acc` 0 (read) requires leaf bit 2, 1 (write) requires bit 3 and 2 (execute) requires bit 4; code 3 is never permitted. A missing permission faults with `rsp_cause`=2 and `rsp_level`=3. On any fault, `rsp_pa` and `rsp_perm` are zero.
- R9: A walk that stops at level L issues exactly L+1 descriptor reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| root_base | input | 48 | Address of the level-0 table |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor value |
| rsp_valid | output | 1 | Translation result, one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 permission, 3 non-canonical |
| rsp_level | output | 2 | Level at which the walk stopped |
| rsp_pa | output | 48 | Physical address |
| rsp_perm | output | 3 | Leaf permissions {X, W, R} |

## Verification
The assertions rely on the memory side returning exactly one `mem_rsp_valid` pulse per accepted read. That pulse must come while the walker waits for it and never at any other time, and `req_valid` is taken to matter only while `req_ready` is high. The bench memory model answers one cycle after each read handshake and varies `mem_req_ready` in a repeating pattern. The bench raises a request only while the walker is idle and drops it right after acceptance, so it stays inside these assumptions. Access codes are limited to read, write and execute.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_INVALID  = 2'd1,
    CAUSE_PERM     = 2'd2,
    CAUSE_NONCANON = 2'd3
  } cause_t;

  typedef enum logic [1:0] {
    DK_INVALID = 2'd0,
    DK_TABLE   = 2'd1,
    DK_PAGE    = 2'd2
  } desc_kind_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int PERM_LSB = 2;
  localparam int PERM_W   = 3;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  addr
);
  localparam int ENT_SHIFT = OFF_W - IDX_W;

  logic [IDX_W-1:0] slice [LEVELS];

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_slice
      assign slice[g] = va[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
    end
  endgenerate

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                 input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] aligned;
    aligned = {tbl[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    return aligned + (PA_W'(idx) << ENT_SHIFT);
  endfunction

  assign addr = entry_addr(base, slice[level]);

  wire unused_va_bits = ^va[OFF_W-1:0];
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode
  import ptw_pkg::*;
#(
  parameter int PA_W   = 48,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [63:0]        desc,
  input  logic [LVL_W-1:0]   level,
  input  logic [1:0]         acc,
  output desc_kind_t         kind,
  output logic [PA_W-1:0]    next_addr,
  output logic [PERM_W-1:0]  perm,
  output logic               perm_ok
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS-1);

  always_comb begin
    if (!desc[0])
      kind = DK_INVALID;
    else if (!desc[1])
      kind = DK_INVALID;
    else if (level == LAST)
      kind = DK_PAGE;
    else
      kind = DK_TABLE;
  end

  assign next_addr = {desc[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign perm      = desc[PERM_LSB +: PERM_W];

  always_comb begin
    case (acc)
      ACC_READ:  perm_ok = perm[0];
      ACC_WRITE: perm_ok = perm[1];
      ACC_EXEC:  perm_ok = perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  wire unused_desc_bits = ^{desc[63:PA_W], desc[OFF_W-1:PERM_LSB+PERM_W]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_va,
  input  logic [1:0]         req_acc,
  input  logic [PA_W-1:0]    root_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [PERM_W-1:0]  rsp_perm
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t               state;
  logic [VA_W-1:0]      va_q;
  logic [1:0]           acc_q;
  logic [PA_W-1:0]      base_q;
  logic [LVL_W-1:0]     level_q;
  logic                 fault_q;
  cause_t               cause_q;
  logic [PA_W-1:0]      pa_q;
  logic [PERM_W-1:0]    perm_q;

  function automatic logic is_canonical(input logic [63:0] v);
    return (&v[63:VA_W-1]) | ~(|v[63:VA_W-1]);
  endfunction

  // named internal events
  wire walk_start = req_valid && req_ready;
  wire req_canon  = is_canonical(req_va);
  wire desc_take  = (state == S_WAIT) && mem_rsp_valid;

  desc_kind_t          kind;
  logic [PA_W-1:0]     next_addr;
  logic [PERM_W-1:0]   leaf_perm;
  logic                perm_ok;

  ptw_index #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
              .LEVELS(LEVELS)) u_index (
    .va(va_q), .level(level_q), .base(base_q), .addr(mem_req_addr)
  );

  ptw_decode #(.PA_W(PA_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) u_decode (
    .desc(mem_rsp_data), .level(level_q), .acc(acc_q), .kind(kind),
    .next_addr(next_addr), .perm(leaf_perm), .perm_ok(perm_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      level_q <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      pa_q    <= '0;
      perm_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (walk_start) begin
          va_q    <= req_va[VA_W-1:0];
          acc_q   <= req_acc;
          base_q  <= {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
          level_q <= '0;
          pa_q    <= '0;
          perm_q  <= '0;
          if (!req_canon) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_NONCANON;
            state   <= S_DONE;
          end else begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            state   <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (desc_take) begin
          case (kind)
            DK_TABLE: begin
              base_q  <= next_addr;
              level_q <= level_q + LVL_W'(1);
              state   <= S_ISSUE;
            end
            DK_PAGE: begin
              if (perm_ok) begin
                pa_q   <= {next_addr[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                perm_q <= leaf_perm;
              end else begin
                fault_q <= 1'b1;
                cause_q <= CAUSE_PERM;
              end
              state <= S_DONE;
            end
            default: begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_INVALID;
              state   <= S_DONE;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign rsp_valid     = (state == S_DONE);
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_level     = level_q;
  assign rsp_pa        = pa_q;
  assign rsp_perm      = perm_q;

  wire unused_root = ^root_base[OFF_W-1:0];

  // R1: a response is a single pulse and the walker is idle right after it
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R1: an accepted request makes the walker busy
  assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);

  // R2: non-canonical request answers next cycle with no read
  assert_noncanon_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_start && !req_canon) |=> (rsp_valid && rsp_fault &&
      rsp_cause == CAUSE_NONCANON && !mem_req_valid));

  // R3: a pending read keeps its address
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: descriptor reads are 8-byte aligned
  assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  // R7: success is only reported at the last level
  assert_success_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_level == LVL_W'(LEVELS-1) && rsp_cause == CAUSE_NONE));

  // R8: permission faults happen at the leaf and carry zeroed results
  assert_perm_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == CAUSE_PERM) |->
      (rsp_level == LVL_W'(LEVELS-1) && rsp_pa == '0 && rsp_perm == '0));
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [47:0] root_base = 48'h0000_0000_1ABC;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [1:0]  rsp_level;
  logic [47:0] rsp_pa;
  logic [2:0]  rsp_perm;

  int checks = 0;
  int failures = 0;
  int rd_count = 0;
  int rdy_ctr = 0;
  int cycles = 0;
  logic [47:0] next_tab = 48'h2000;
  logic [63:0] mem [logic [47:0]];

  always #2 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_level(rsp_level), .rsp_pa(rsp_pa),
    .rsp_perm(rsp_perm)
  );

  // memory model: answers one cycle after each read handshake
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= 1'b0;
      rdy_ctr       <= 0;
    end else begin
      rdy_ctr       <= rdy_ctr + 1;
      mem_req_ready <= (rdy_ctr % 3) != 0;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        rd_count     <= rd_count + 1;
        mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      end
    end
  end

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(input logic [8:0] i0, input logic [8:0] i1,
                                       input logic [8:0] i2, input logic [8:0] i3,
                                       input logic [11:0] off);
    logic [47:0] v;
    v = {i0, i1, i2, i3, off};
    return {{16{v[47]}}, v};
  endfunction

  function automatic logic [47:0] slot(input logic [47:0] tbl, input logic [63:0] va,
                                       input int lvl);
    int sh;
    logic [63:0] ix;
    sh = 39 - 9 * lvl;
    ix = (va >> sh) & 64'd511;
    return (tbl & ~48'hFFF) + 48'(ix * 8);
  endfunction

  // place descriptors along the path of va; stop_lvl < 4 writes stop_val there
  task automatic build(input logic [63:0] va, input int stop_lvl,
                       input logic [63:0] stop_val, input logic [63:0] leaf);
    logic [47:0] tbl;
    logic [47:0] a;
    tbl = root_base & ~48'hFFF;
    for (int l = 0; l < 4; l++) begin
      a = slot(tbl, va, l);
      if (l == stop_lvl) begin
        mem[a] = stop_val;
        return;
      end
      if (l == 3) begin
        mem[a] = leaf;
      end else if (mem.exists(a) && mem[a][1:0] == 2'b11) begin
        tbl = {mem[a][47:12], 12'h0};
      end else begin
        // R5: stray bits outside 47..12 must be ignored
        mem[a] = 64'hF5A0_0000_0000_0FFC | {16'h0, next_tab} | 64'h3;
        tbl = next_tab;
        next_tab = next_tab + 48'h1000;
      end
    end
  endtask

  function automatic logic [63:0] leaf_desc(input logic [35:0] page, input logic [2:0] p,
                                            input logic [1:0] kind_bits);
    return 64'h8F00_0000_0000_0FE0 | ({28'h0, page} << 12) | (64'(p) << 2) | 64'(kind_bits);
  endfunction

  task automatic walk(input logic [63:0] va, input logic [1:0] acc, input bit e_fault,
                      input logic [1:0] e_cause, input logic [1:0] e_level,
                      input logic [47:0] e_pa, input logic [2:0] e_perm,
                      input int e_reads, input string tag);
    int start;
    int n;
    @(negedge clk);
    start = rd_count;
    req_va = va;
    req_acc = acc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {"R1 busy after accept ", tag}, 64'(req_ready), 64'd0);
    n = 0;
    while (!rsp_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n < 2000, {"R1 response timeout ", tag}, 64'(n), 64'd0);
    check(rsp_fault == e_fault, {tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    check(rsp_cause == e_cause, {tag, " cause"}, 64'(rsp_cause), 64'(e_cause));
    check(rsp_level == e_level, {tag, " level"}, 64'(rsp_level), 64'(e_level));
    check(rsp_pa == e_pa, {tag, " pa"}, 64'(rsp_pa), 64'(e_pa));
    check(rsp_perm == e_perm, {tag, " perm"}, 64'(rsp_perm), 64'(e_perm));
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, {"R1 single pulse ", tag},
          64'({rsp_valid, req_ready}), 64'b01);
    check(rd_count - start == e_reads, {"R9 read count ", tag},
          64'(rd_count - start), 64'(e_reads));
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [35:0] page;
    bit allowed;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0,
          "R1 reset state", 64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 / R8: permission sweep on one mapping
    va = mkva(9'd1, 9'd2, 9'd3, 9'd4, 12'hABC);
    page = 36'h0_000A_BCDE;
    for (int p = 0; p < 8; p++) begin
      build(va, 4, 64'h0, leaf_desc(page, 3'(p), 2'b11));
      for (int a = 0; a < 3; a++) begin
        allowed = ((p >> a) & 1) == 1;
        if (allowed)
          walk(va, 2'(a), 1'b0, 2'd0, 2'd3, {page, 12'hABC}, 3'(p), 4, "R7 perm ok");
        else
          walk(va, 2'(a), 1'b1, 2'd2, 2'd3, 48'h0, 3'd0, 4, "R8 perm denied");
      end
    end

    // R3 / R5: index sweep over many addresses, both halves
    for (int k = 0; k < 16; k++) begin
      va = mkva(9'(k * 37 + 5), 9'(k * 11 + 3), 9'(k * 5 + 1), 9'(k * 3 + 7), 12'(k * 123));
      page = 36'h5_0000 + 36'(k * 7);
      build(va, 4, 64'h0, leaf_desc(page, 3'b001, 2'b11));
    end
    for (int k = 0; k < 16; k++) begin
      va = mkva(9'(k * 37 + 5), 9'(k * 11 + 3), 9'(k * 5 + 1), 9'(k * 3 + 7), 12'(k * 123));
      page = 36'h5_0000 + 36'(k * 7);
      walk(va, 2'd0, 1'b0, 2'd0, 2'd3, {page, va[11:0]}, 3'b001, 4, "R3 index sweep");
    end

    // R4: invalid descriptor (bit 0 clear) at each level
    for (int l = 0; l < 4; l++) begin
      va = mkva(9'(500 + l), 9'd9, 9'd8, 9'd7, 12'h123);
      build(va, l, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0);
      if (l < 3)
        walk(va, 2'd0, 1'b1, 2'd1, 2'(l), 48'h0, 3'd0, l + 1, "R4 invalid bit0");
      else
        walk(va, 2'd0, 1'b1, 2'd1, 2'd3, 48'h0, 3'd0, 4, "R6 leaf bit0 clear");
    end
    // R4: valid-but-not-table pattern 01 at levels 0..2
    for (int l = 0; l < 3; l++) begin
      va = mkva(9'(504 + l), 9'd1, 9'd1, 9'd1, 12'h0);
      build(va, l, 64'h0000_0000_0033_3001, 64'h0);
      walk(va, 2'd0, 1'b1, 2'd1, 2'(l), 48'h0, 3'd0, l + 1, "R4 pattern 01");
    end
    // R6: level-3 patterns 01 and 10
    va = mkva(9'd508, 9'd2, 9'd2, 9'd2, 12'h0);
    build(va, 4, 64'h0, leaf_desc(36'h1234, 3'b111, 2'b01));
    walk(va, 2'd0, 1'b1, 2'd1, 2'd3, 48'h0, 3'd0, 4, "R6 leaf 01");
    va = mkva(9'd509, 9'd2, 9'd2, 9'd2, 12'h0);
    build(va, 4, 64'h0, leaf_desc(36'h1234, 3'b111, 2'b10));
    walk(va, 2'd0, 1'b1, 2'd1, 2'd3, 48'h0, 3'd0, 4, "R6 leaf 10");

    // R2: non-canonical addresses
    walk(64'h0001_0000_0000_1000, 2'd0, 1'b1, 2'd3, 2'd0, 48'h0, 3'd0, 0, "R2 noncanon low");
    walk(64'hFFFE_8000_0000_1000, 2'd1, 1'b1, 2'd3, 2'd0, 48'h0, 3'd0, 0, "R2 noncanon high");
    walk(64'h8000_0000_0000_0000, 2'd2, 1'b1, 2'd3, 2'd0, 48'h0, 3'd0, 0, "R2 noncanon top");
    walk(64'h0000_8000_0000_0000, 2'd0, 1'b1, 2'd3, 2'd0, 48'h0, 3'd0, 0, "R2 bit47 only");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule